// File: doc/BRIEF.md
# Instruction Fetch and Next-PC Unit

This block owns the program counter of a single-cycle processor and supplies the instruction word stored at that address. A small word-addressed instruction store sits inside the block. It is read combinationally, so the fetched word is valid in the same cycle that the PC holds its address. On every rising clock edge the PC advances to one of three successors: the sequential address, a conditional PC-relative branch target, or a jump target inside the current 256 MB region.

The surrounding decoder drives a two-bit successor select, and the datapath supplies its zero flag. The decoder also returns the 16-bit immediate and the 26-bit jump target that it split out of the fetched word. A write port loads the instruction store before a program runs, and it is used only by the testbench.

Top module: `ifetch_unit`

## Requirements
- R1: While rst_ni is low, pc_o is 0x00000000, and it remains 0 at every clock edge during reset.
- R2: instr_o always equals the stored word at index pc_o[9:2] of the 256-word store, with no clock delay.
- R3: With npc_sel_i = 2'b00 (sequential), the PC after the clock edge is PC+4.
- R4: With npc_sel_i = 2'b01 (branch) and zero_i = 1, the PC after the edge is PC+4 plus the sign-extended imm_i shifted left by two. The addition wraps modulo 2^32.
- R5: With npc_sel_i = 2'b01 (branch) and zero_i = 0, the PC after the edge is PC+4.
- R6: With npc_sel_i = 2'b10 (jump), the PC after the edge is {(PC+4)[31:28], jtarget_i, 2'b00}.
- R7: npc_sel_i = 2'b11 (branch and jump bits both set) behaves as a jump, whatever the value of zero_i.
- R8: pc_o[1:0] is 2'b00 in every cycle.
- R9: When ld_en_i is high at a rising edge, ld_data_i is stored at word index ld_idx_i. From then on that word appears on instr_o whenever the PC selects that index, including during reset.
- R10: zero_i has no effect when npc_sel_i is sequential or jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset; clears the PC |
| npc_sel_i | input | 2 | Successor select: 00 sequential, 01 branch, 10 or 11 jump |
| zero_i | input | 1 | ALU zero flag; qualifies the branch |
| imm_i | input | 16 | Branch word offset, signed |
| jtarget_i | input | 26 | Jump word target within the current region |
| ld_en_i | input | 1 | Instruction store write enable (testbench preload) |
| ld_idx_i | input | 8 | Instruction store write word index |
| ld_data_i | input | 32 | Instruction store write data |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Instruction word at the current PC |

## Verification
Assertions check every cycle that the PC stays word-aligned, that it holds zero under reset, and that each select value produces its successor: PC+4 for sequential and for an untaken branch, the scaled offset for a taken branch, and the region jump (with jump winning when both select bits are set). Only the bench scenarios can show that the instruction store returns the preloaded words at the addresses the PC visits. They also cover the boundary values: a branch that wraps below zero into the top region, a jump taken from that region, and the largest positive and negative offsets. Finally, they show that zero_i has no effect outside a branch.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
  typedef enum logic [1:0] {
    NPC_SEQ     = 2'b00,
    NPC_BR      = 2'b01,
    NPC_JMP     = 2'b10,
    NPC_BR_JMP  = 2'b11
  } npc_sel_e;
endpackage

// File: rtl/ifu_npc.sv
module ifu_npc #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int TGT_W  = 26
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [1:0]        sel_i,
  input  logic              zero_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [TGT_W-1:0]  tgt_i,
  output logic [ADDR_W-1:0] npc_o
);
  import ifu_pkg::*;

  localparam int SEXT_W = ADDR_W - IMM_W - 2;
  localparam int REG_W  = ADDR_W - TGT_W - 2;

  logic [ADDR_W-1:0] pc_plus4;
  logic [ADDR_W-1:0] br_off;
  logic [ADDR_W-1:0] jmp_tgt;
  npc_sel_e          sel;

  assign sel      = npc_sel_e'(sel_i);
  assign pc_plus4 = pc_i + ADDR_W'(4);
  assign br_off   = {{SEXT_W{imm_i[IMM_W-1]}}, imm_i, 2'b00};
  assign jmp_tgt  = {pc_plus4[ADDR_W-1 -: REG_W], tgt_i, 2'b00};

  // jump bit dominates the branch bit
  always_comb begin
    unique case (sel)
      NPC_BR:             npc_o = zero_i ? pc_plus4 + br_off : pc_plus4;
      NPC_JMP, NPC_BR_JMP: npc_o = jmp_tgt;
      default:            npc_o = pc_plus4;
    endcase
  end
endmodule

// File: rtl/ifu_pc_reg.sv
module ifu_pc_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] npc_i,
  output logic [ADDR_W-1:0] pc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_o <= '0;
    else         pc_o <= {npc_i[ADDR_W-1:2], 2'b00};
  end

  assert_aligned_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_o[1:0] == 2'b00);

  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_pc_R1: assert (pc_o == '0);
  end
endmodule

// File: rtl/ifu_imem.sv
module ifu_imem #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[wr_idx_i] <= wr_data_i;
  end

  assign rd_data_o = mem[rd_idx_i];
endmodule

// File: rtl/ifetch_unit.sv
module ifetch_unit #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int IMM_W      = 16,
  parameter int TGT_W      = 26,
  parameter int IMEM_DEPTH = 256,
  localparam int IDX_W     = $clog2(IMEM_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        npc_sel_i,
  input  logic              zero_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [TGT_W-1:0]  jtarget_i,
  input  logic              ld_en_i,
  input  logic [IDX_W-1:0]  ld_idx_i,
  input  logic [DATA_W-1:0] ld_data_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] instr_o
);
  localparam int SEXT_W = ADDR_W - IMM_W - 2;
  localparam int REG_W  = ADDR_W - TGT_W - 2;

  logic [ADDR_W-1:0] npc;

  ifu_npc #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .TGT_W(TGT_W)) u_npc (
    .pc_i   (pc_o),
    .sel_i  (npc_sel_i),
    .zero_i (zero_i),
    .imm_i  (imm_i),
    .tgt_i  (jtarget_i),
    .npc_o  (npc)
  );

  ifu_pc_reg #(.ADDR_W(ADDR_W)) u_pc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .npc_i  (npc),
    .pc_o   (pc_o)
  );

  ifu_imem #(.DATA_W(DATA_W), .DEPTH(IMEM_DEPTH)) u_imem (
    .clk_i     (clk_i),
    .we_i      (ld_en_i),
    .wr_idx_i  (ld_idx_i),
    .wr_data_i (ld_data_i),
    .rd_idx_i  (pc_o[IDX_W+1:2]),
    .rd_data_o (instr_o)
  );

  assert_seq_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    npc_sel_i == 2'b00 |=> pc_o == $past(pc_o) + ADDR_W'(4));

  assert_br_taken_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (npc_sel_i == 2'b01 && zero_i) |=>
      pc_o == $past(pc_o) + ADDR_W'(4) + {{SEXT_W{$past(imm_i[IMM_W-1])}}, $past(imm_i), 2'b00});

  assert_br_not_taken_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (npc_sel_i == 2'b01 && !zero_i) |=> pc_o == $past(pc_o) + ADDR_W'(4));

  assert_jump_R6_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    npc_sel_i[1] |=> (pc_o[TGT_W+1:0] == {$past(jtarget_i), 2'b00}) &&
      (pc_o[ADDR_W-1 -: REG_W] == $past(pc_o[ADDR_W-1 -: REG_W] + REG_W'(pc_o[ADDR_W-REG_W-1:2] == '1 ? 1 : 0))));
endmodule

// File: tb/tb_ifetch_unit.sv
module tb_ifetch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  sel = 2'b00;
  logic        zero = 1'b0;
  logic [15:0] imm = '0;
  logic [25:0] tgt = '0;
  logic        ld_en = 1'b0;
  logic [7:0]  ld_idx = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] pc, instr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] model [256];
  logic [31:0] exp_pc;

  always #4 clk = ~clk;

  ifetch_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .npc_sel_i(sel), .zero_i(zero),
    .imm_i(imm), .jtarget_i(tgt), .ld_en_i(ld_en), .ld_idx_i(ld_idx),
    .ld_data_i(ld_data), .pc_o(pc), .instr_o(instr)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] next_pc(logic [31:0] p, logic [1:0] s, logic z,
                                          logic [15:0] i, logic [25:0] t);
    logic [31:0] p4;
    p4 = p + 32'd4;
    if (s[1])        return {p4[31:28], t, 2'b00};
    else if (s[0] && z) return p4 + {{14{i[15]}}, i, 2'b00};
    else             return p4;
  endfunction

  // apply at negedge, check at next negedge
  task automatic step(logic [1:0] s, logic z, logic [15:0] i, logic [25:0] t, string req);
    sel = s; zero = z; imm = i; tgt = t;
    exp_pc = next_pc(exp_pc, s, z, i, t);
    @(negedge clk);
    chk(req, pc, exp_pc);
    chk({req, "/R8"}, {30'd0, pc[1:0]}, 32'd0);
    chk({req, "/R2"}, instr, model[exp_pc[9:2]]);
  endtask

  initial begin
    #(8 * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // preload under reset (R9)
    @(negedge clk);
    for (int k = 0; k < 256; k++) begin
      ld_en = 1'b1; ld_idx = k[7:0];
      ld_data = 32'h5A000000 ^ (k * 32'h00010203) ^ k;
      model[k] = ld_data;
      @(negedge clk);
    end
    ld_en = 1'b0;
    chk("R1", pc, 32'd0);
    chk("R9", instr, model[0]);
    // overwrite index 0 during reset, visible after the edge (R9)
    ld_en = 1'b1; ld_idx = 8'd0; ld_data = 32'hCAFEF00D; model[0] = 32'hCAFEF00D;
    @(negedge clk);
    ld_en = 1'b0;
    chk("R9", instr, 32'hCAFEF00D);
    chk("R1", pc, 32'd0);
    rst_n = 1'b1;
    exp_pc = 32'd0;

    // sequential with zero set: zero ignored (R3, R10)
    step(2'b00, 1'b1, 16'hFFFF, 26'h3FFFFFF, "R3/R10");
    step(2'b00, 1'b0, 16'h0000, 26'h0, "R3");
    // untaken branch (R5)
    step(2'b01, 1'b0, 16'h0040, 26'h0, "R5");
    // taken forward/backward branches (R4)
    step(2'b01, 1'b1, 16'h0010, 26'h0, "R4");
    step(2'b01, 1'b1, 16'hFFFF, 26'h0, "R4");
    step(2'b01, 1'b1, 16'h7FFF, 26'h0, "R4");
    step(2'b01, 1'b1, 16'h8000, 26'h0, "R4");
    // jump from low region (R6), zero ignored (R10)
    step(2'b10, 1'b1, 16'h1234, 26'h0000003, "R6/R10");
    // wrap below zero into top region (R4)
    step(2'b01, 1'b1, 16'hFFF8, 26'h0, "R4");
    chk("R4", pc, 32'hFFFFFFF0);
    // jump keeps upper region bits F (R6)
    step(2'b10, 1'b0, 16'h0, 26'h2ABCDEF, "R6");
    chk("R6", pc, {4'hF, 26'h2ABCDEF, 2'b00});
    // both bits set acts as jump for either zero (R7)
    step(2'b11, 1'b1, 16'h0100, 26'h0000010, "R7");
    step(2'b11, 1'b0, 16'h0100, 26'h0000020, "R7");
    // jump to region edge, then sequential rolls region for later jumps
    step(2'b10, 1'b0, 16'h0, 26'h3FFFFFF, "R6");
    step(2'b10, 1'b0, 16'h0, 26'h0000005, "R6");

    // near-exhaustive sweep of select, zero and operand values
    for (int n = 0; n < 4000; n++) begin
      logic [1:0] s;
      logic z;
      s = 2'(n % 4);
      z = n[2];
      step(s, z, 16'($urandom), 26'($urandom),
           s[1] ? (s[0] ? "R7" : "R6") : (s[0] ? (z ? "R4" : "R5") : "R3"));
    end

    // reset mid-run returns PC to 0 (R1)
    #1 rst_n = 1'b0;
    #1 chk("R1", pc, 32'd0);
    @(negedge clk);
    chk("R1", pc, 32'd0);
    chk("R2", instr, model[0]);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule